// File: doc/BRIEF.md
# Forward 4x4 Hadamard Transform for DC Terms

This block takes a 4x4 tile of signed 16-bit values, one row of four values per accepted transfer, and returns the 4x4 forward Walsh-Hadamard transform of that tile with the fixed-point scaling and rounding a video encoder needs for the second-stage transform of its DC coefficients. The result is bit exact against an integer model. An upstream producer streams in four rows with a valid/ready handshake. Four result rows then come out through a second valid/ready handshake, one per accepted transfer.

Every incoming row first has each value scaled by four. It then goes through a 16-bit butterfly, and the result is written into a tile buffer. When the fourth row has been stored, the block stops accepting input. A 32-bit butterfly then runs down each column of the buffer. Each column result is rounded with a sign-dependent bias, shifted right by three and clamped to 16 bits. Each output row gathers the same butterfly term from all four columns. Input is accepted again once the fourth result row has been taken.

Top module: `dc_hadamard4`

## Requirements
- R1: While and directly after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Lane j of `in_row` and `out_row` sits in bits [16j+15:16j] and stands for column j. Each input value is multiplied by 4 with the result wrapped to 16 bits.
- R3: For each scaled row s, the row pass forms p=s0+s2, q=s0-s2, u=s1+s3, w=s1-s3, all wrapped to 16 bits. Its four values in column order are p+u+(p!=0 ? 1 : 0), q+w, q-w and p-u, each wrapped to 16 bits.
- R4: For each column, taking row-pass values r0..r3 sign-extended to 32 bits, the column pass forms P=r0+r2, Q=r0-r2, U=r1+r3, W=r1-r3. Its terms in order are P+U, Q+W, Q-W and P-U.
- R5: Each column term v becomes (v + (v<0 ? 1 : 0) + 3) shifted right arithmetically by 3, then clamped to [-32768, 32767].
- R6: The four result rows come out in order 0 to 3. Result row k holds the k-th column-pass term of every column, so the tile reads out in row-major order.
- R7: `in_ready` is 0 from the cycle after the fourth input row is accepted until the last result row is accepted. `in_valid` and `in_row` have no effect during that time.
- R8: `out_valid` rises in the cycle right after the fourth input row is accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_row` does not change.
- R10: In the cycle after the fourth result row is accepted, `in_ready` is 1 and `out_valid` is 0, so the next tile can begin at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input row is offered |
| in_ready | output | 1 | The block takes an input row |
| in_row | input | 64 | Four signed 16-bit input values, lane 0 in the low bits |
| out_valid | output | 1 | A result row is offered |
| out_ready | input | 1 | Downstream takes the result row |
| out_row | output | 64 | Four signed 16-bit results, lane 0 in the low bits |

## Verification
Results are driven from registers, so result row 0 is on `out_row` in the first cycle after the edge that accepts the fourth input row. Each later row appears in the cycle after the previous row is accepted. The bench keeps a behavioural model of the tile and of both handshakes. At every falling edge it predicts `in_ready`, `out_valid` and the current result row, and compares them with the ports. It then picks the inputs for the next rising edge and advances its model by exactly the transfers that edge will complete. Random stalls on both sides, and junk rows offered while input is closed, check the hold and ignore rules cycle by cycle.

// File: rtl/dch4_pkg.sv
package dch4_pkg;

    // Transform order is fixed by the butterfly structure.
    localparam int unsigned N       = 4;
    localparam int unsigned IDX_W   = $clog2(N);

    // Default datapath settings.
    localparam int unsigned DEF_DW   = 16;
    localparam int unsigned DEF_AW   = 32;
    localparam int unsigned DEF_PRE  = 2;
    localparam int unsigned DEF_POST = 3;
    localparam int unsigned DEF_BIAS = 3;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [IDX_W-1:0]   wr_idx;
        logic [IDX_W-1:0]   rd_idx;
    } ctl_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

endpackage

// File: rtl/dch4_row_pass.sv
module dch4_row_pass
    import dch4_pkg::*;
#(
    parameter int unsigned DW  = DEF_DW,
    parameter int unsigned PRE = DEF_PRE
) (
    input  logic [N*DW-1:0] row_i,
    output logic [N*DW-1:0] row_o
);

    logic signed [DW-1:0] s [N];

    for (genvar g = 0; g < N; g++) begin : g_scale
        assign s[g] = $signed(row_i[g*DW +: DW]) <<< PRE;
    end

    logic signed [DW-1:0] sp, sq, su, sw;
    logic signed [DW-1:0] y0, y1, y2, y3;

    always_comb begin
        sp = s[0] + s[2];
        sq = s[0] - s[2];
        su = s[1] + s[3];
        sw = s[1] - s[3];
        y0 = sp + su + {{(DW-1){1'b0}}, (sp != '0)};
        y1 = sq + sw;
        y2 = sq - sw;
        y3 = sp - su;
    end

    assign row_o = {y3, y2, y1, y0};

endmodule

// File: rtl/dch4_col_pass.sv
module dch4_col_pass
    import dch4_pkg::*;
#(
    parameter int unsigned DW = DEF_DW,
    parameter int unsigned AW = DEF_AW
) (
    input  logic [N*N*DW-1:0] tile_i,
    input  logic [IDX_W-1:0]  sel_i,
    output logic [N*AW-1:0]   row_o
);

    function automatic logic signed [AW-1:0] sx(input logic [DW-1:0] x);
        return {{(AW-DW){x[DW-1]}}, x};
    endfunction

    for (genvar c = 0; c < N; c++) begin : g_col
        logic signed [AW-1:0] r0, r1, r2, r3;
        logic signed [AW-1:0] cp, cq, cu, cw;
        logic signed [AW-1:0] term;

        assign r0 = sx(tile_i[(0*N + c)*DW +: DW]);
        assign r1 = sx(tile_i[(1*N + c)*DW +: DW]);
        assign r2 = sx(tile_i[(2*N + c)*DW +: DW]);
        assign r3 = sx(tile_i[(3*N + c)*DW +: DW]);

        always_comb begin
            cp = r0 + r2;
            cq = r0 - r2;
            cu = r1 + r3;
            cw = r1 - r3;
            case (sel_i)
                2'd0:    term = cp + cu;
                2'd1:    term = cq + cw;
                2'd2:    term = cq - cw;
                default: term = cp - cu;
            endcase
        end

        assign row_o[c*AW +: AW] = term;
    end

endmodule

// File: rtl/dch4_finish.sv
module dch4_finish
    import dch4_pkg::*;
#(
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned AW   = DEF_AW,
    parameter int unsigned POST = DEF_POST,
    parameter int unsigned BIAS = DEF_BIAS
) (
    input  logic [N*AW-1:0] acc_i,
    output logic [N*DW-1:0] res_o
);

    localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [AW-1:0] BIAS_V = AW'(BIAS);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic signed [AW-1:0] v, t, q;
        logic [DW-1:0]        lane;

        assign v = $signed(acc_i[g*AW +: AW]);
        assign t = v + $signed({{(AW-1){1'b0}}, v[AW-1]}) + BIAS_V;
        assign q = t >>> POST;

        always_comb begin
            if (q > HI)      lane = HI[DW-1:0];
            else if (q < LO) lane = LO[DW-1:0];
            else             lane = q[DW-1:0];
        end

        assign res_o[g*DW +: DW] = lane;
    end

endmodule

// File: rtl/dc_hadamard4.sv
module dc_hadamard4
    import dch4_pkg::*;
#(
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned AW   = DEF_AW,
    parameter int unsigned PRE  = DEF_PRE,
    parameter int unsigned POST = DEF_POST,
    parameter int unsigned BIAS = DEF_BIAS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [N*DW-1:0] in_row,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [N*DW-1:0] out_row
);

    localparam int unsigned ROW_W  = N * DW;
    localparam int unsigned TILE_W = N * ROW_W;

    ctl_t              ctl;
    logic [TILE_W-1:0] tile_q;
    logic [ROW_W-1:0]  row_fp;
    logic [N*AW-1:0]   col_terms;

    logic in_fire, out_fire;

    assign in_ready  = (ctl.ph == PH_FILL);
    assign out_valid = (ctl.ph == PH_DRAIN);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;

    dch4_row_pass #(.DW(DW), .PRE(PRE)) u_row (
        .row_i (in_row),
        .row_o (row_fp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '{ph: PH_FILL, wr_idx: '0, rd_idx: '0};
            tile_q <= '0;
        end else begin
            if (in_fire) begin
                tile_q[ctl.wr_idx*ROW_W +: ROW_W] <= row_fp;
                ctl.wr_idx <= ctl.wr_idx + 1'b1;
                if (ctl.wr_idx == LAST_IDX) ctl.ph <= PH_DRAIN;
            end
            if (out_fire) begin
                ctl.rd_idx <= ctl.rd_idx + 1'b1;
                if (ctl.rd_idx == LAST_IDX) ctl.ph <= PH_FILL;
            end
        end
    end

    dch4_col_pass #(.DW(DW), .AW(AW)) u_col (
        .tile_i (tile_q),
        .sel_i  (ctl.rd_idx),
        .row_o  (col_terms)
    );

    dch4_finish #(.DW(DW), .AW(AW), .POST(POST), .BIAS(BIAS)) u_fin (
        .acc_i (col_terms),
        .res_o (out_row)
    );

    // R7
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R8
    fill_done_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fire && ctl.wr_idx == LAST_IDX) |=> out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    // R10
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fire && ctl.rd_idx == LAST_IDX) |=> (in_ready && !out_valid));

    // R6
    order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (ctl.rd_idx == '0));

endmodule

// File: tb/dc_hadamard4_bench.sv
module dc_hadamard4_bench;

    localparam int NB = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_row = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_row;

    always #5 clk = ~clk;

    dc_hadamard4 u_dc_hadamard4 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    shortint tiles [NB][16];
    int      expv  [16];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp16(input int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    // Behavioural model: R2 scaling, R3 row pass, R4 column pass, R5 rounding, R6 order
    task automatic model(input int b);
        shortint fp [4][4];
        for (int r = 0; r < 4; r++) begin
            shortint s [4];
            shortint p, q, u, w;
            for (int j = 0; j < 4; j++) s[j] = shortint'(int'(tiles[b][r*4+j]) * 4);
            p = shortint'(int'(s[0]) + int'(s[2]));
            q = shortint'(int'(s[0]) - int'(s[2]));
            u = shortint'(int'(s[1]) + int'(s[3]));
            w = shortint'(int'(s[1]) - int'(s[3]));
            fp[r][0] = shortint'(int'(p) + int'(u) + ((p != 0) ? 1 : 0));
            fp[r][1] = shortint'(int'(q) + int'(w));
            fp[r][2] = shortint'(int'(q) - int'(w));
            fp[r][3] = shortint'(int'(p) - int'(u));
        end
        for (int c = 0; c < 4; c++) begin
            int cp, cq, cu, cw;
            int t [4];
            cp = int'(fp[0][c]) + int'(fp[2][c]);
            cq = int'(fp[0][c]) - int'(fp[2][c]);
            cu = int'(fp[1][c]) + int'(fp[3][c]);
            cw = int'(fp[1][c]) - int'(fp[3][c]);
            t[0] = cp + cu; t[1] = cq + cw; t[2] = cq - cw; t[3] = cp - cu;
            for (int k = 0; k < 4; k++)
                expv[k*4+c] = clamp16((t[k] + ((t[k] < 0) ? 1 : 0) + 3) >>> 3);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 10000; i++) @(posedge clk);
        check(0, "watchdog", "timeout", 0, 1);
        summary();
    end

    initial begin
        int ph = 0, rc = 0, oc = 0, blk = 0;
        bit hold = 0;
        logic [63:0] prev = '0;

        // Tile contents: zeros, full scale, a tile whose rows have p == 0, random
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 16; i++) begin
                case (b)
                    0: tiles[b][i] = 16'sd0;
                    1: tiles[b][i] = 16'sd32767;
                    2: tiles[b][i] = -16'sd32768;
                    3: tiles[b][i] = (i % 2 == 0) ? 16'sd32767 : -16'sd32768;
                    4: tiles[b][i] = ((i % 4) == 0) ? 16'sd9 : ((i % 4) == 2) ? -16'sd9 : shortint'(i * 37 - 200);
                    5: tiles[b][i] = ((i % 4) == 0) ? -16'sd1 : 16'sd1;
                    default: tiles[b][i] = shortint'($urandom);
                endcase
            end

        @(posedge clk); @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        check(in_ready == 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;

        while (blk < NB) begin
            @(negedge clk);
            // R7 / R10: input side open only while filling
            check(in_ready == (ph == 0), "R7 R10", "in_ready", longint'(in_ready), longint'(ph == 0));
            // R8: results offered while draining
            check(out_valid == (ph == 1), "R8", "out_valid", longint'(out_valid), longint'(ph == 1));
            if (ph == 1) begin
                for (int j = 0; j < 4; j++)
                    check($signed(out_row[j*16 +: 16]) == expv[oc*4+j], "R2 R3 R4 R5 R6",
                          $sformatf("tile %0d row %0d lane %0d", blk, oc, j),
                          longint'($signed(out_row[j*16 +: 16])), longint'(expv[oc*4+j]));
                if (hold)
                    check(out_row == prev, "R9", "row held under stall",
                          longint'(out_row[31:0]), longint'(prev[31:0]));
            end

            in_valid  = ($urandom % 10) < 6;
            out_ready = ($urandom % 10) < 7;
            if (ph == 0 && in_valid) begin
                for (int j = 0; j < 4; j++) in_row[j*16 +: 16] = tiles[blk][rc*4+j];
            end else begin
                in_row = {$urandom, $urandom};  // R7: junk offered while closed
            end
            hold = (ph == 1) && !out_ready;
            prev = out_row;

            if (ph == 0) begin
                if (in_valid) begin
                    rc++;
                    if (rc == 4) begin
                        model(blk);
                        rc = 0; oc = 0; ph = 1;
                    end
                end
            end else if (out_ready) begin
                oc++;
                if (oc == 4) begin
                    ph = 0; blk++;
                end
            end
        end

        @(negedge clk);
        // R10: open again after the last row of the last tile
        check(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after drain",
              longint'({in_ready, out_valid}), 2);
        summary();
    end

endmodule